// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs the digital half of a successive approximation conversion. A start request, taken while the block is idle, clears the trial register. The block then walks the trial bits from the most significant bit downward. For each bit it sets the bit, presents the trial code to an external DAC model, and samples a one-bit comparator on the next clock. Then it keeps or drops the bit. The analog parts (DAC, reference and input scaling) sit outside the block. Only the comparator decision reaches it.

A short-cycle select, captured when the conversion starts, picks one of two lengths. One resolves all result bits. The other resolves only the upper bits and leaves the low bits at zero. A conversion that is running cannot be stopped or restarted. A busy output covers the whole conversion. The result output reads zero while busy and shows the finished code afterwards. A one-cycle done pulse marks the edge where busy drops.

Top module: `sar_seq`

## Requirements
- R1: After reset, `busy`, `done`, `dac_code` and `result` are all zero.
- R2: A `start` sampled high while idle raises `busy` on that clock edge, and `dac_code` reads all zeros in the following cycle.
- R3: Trials run from the MSB toward bit 0. The first trial code presented is 12'h800 (only bit 11 set). Each bit takes two cycles: in the first, the trial bit is applied; in the second, the comparator is sampled.
- R4: `cmp_hi` = 1 means the DAC output exceeds the input, and the trial bit is cleared. `cmp_hi` = 0 keeps the bit. With a comparator that reports `dac_code > vin`, a full conversion returns exactly `vin`.
- R5: `short_sel` = 0 at start gives 12 trials and `busy` high for 24 cycles. `short_sel` = 1 gives 8 trials (bits 11..4) and `busy` high for 16 cycles, and result bits 3..0 read zero.
- R6: `short_sel` is captured on the start edge. Changes to it during a conversion do not alter the length or the result.
- R7: `start` pulses while `busy` is high are ignored. The conversion neither restarts nor ends early, and its result is unchanged.
- R8: `busy` stays high for the whole conversion. `done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R9: `result` reads zero while `busy` is high. After the end it holds the converted code until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, taken only while idle |
| short_sel | input | 1 | 1 selects the 8-trial short conversion, captured at start |
| cmp_hi | input | 1 | Comparator: 1 when the DAC output exceeds the input |
| dac_code | output | 12 | Current trial code for the DAC model |
| result | output | 12 | Finished code, zero while busy |
| busy | output | 1 | High for the whole conversion |
| done | output | 1 | One-cycle pulse as busy falls |

## Verification
The bench places an integer input behind a comparator that follows `dac_code`. It checks the extreme inputs 0 and 4095 and alternating bit patterns. A design that tested bits in the wrong order, or inverted the keep/drop rule, would return codes that do not match the input. Both lengths are timed by cycle. A design that read `short_sel` live, rather than capturing it, would change length when the select is toggled mid-run. A design that honoured `start` while busy would restart and stretch `busy` past 24 cycles. The bench also samples `result` mid-conversion and watches `done` around the falling edge of `busy`, which catches a result that leaks while busy and a done pulse that is late or too long.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int unsigned RES_W   = 12;
    localparam int unsigned SHORT_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_APPLY  = 2'd1,
        PH_DECIDE = 2'd2
    } phase_e;

    typedef struct packed {
        logic clear;
        logic set_bit;
        logic decide;
    } trial_cmd_t;

    // Index of the last bit resolved for the selected conversion length
    function automatic int unsigned final_bit(input logic short_mode,
                                              input int unsigned res_w,
                                              input int unsigned short_w);
        return short_mode ? (res_w - short_w) : 0;
    endfunction

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W   = sar_seq_pkg::RES_W,
    parameter int unsigned SHORT_W = sar_seq_pkg::SHORT_W,
    parameter int unsigned IDX_W   = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             short_sel,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx,
    output trial_cmd_t       cmd
);

    localparam logic [IDX_W-1:0] TOP_IDX   = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] FULL_STOP = IDX_W'(final_bit(1'b0, RES_W, SHORT_W));
    localparam logic [IDX_W-1:0] SHRT_STOP = IDX_W'(final_bit(1'b1, RES_W, SHORT_W));

    phase_e           ph;
    logic             short_q;
    logic [IDX_W-1:0] stop_idx;

    assign stop_idx = short_q ? SHRT_STOP : FULL_STOP;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            idx     <= '0;
            short_q <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph      <= PH_APPLY;
                        idx     <= TOP_IDX;
                        short_q <= short_sel;
                    end
                end
                PH_APPLY: ph <= PH_DECIDE;
                PH_DECIDE: begin
                    if (idx == stop_idx) begin
                        ph   <= PH_IDLE;
                        done <= 1'b1;
                    end else begin
                        idx <= idx - 1'b1;
                        ph  <= PH_APPLY;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign busy        = (ph != PH_IDLE);
    assign cmd.clear   = (ph == PH_IDLE) && start;
    assign cmd.set_bit = (ph == PH_APPLY);
    assign cmd.decide  = (ph == PH_DECIDE);

    // Captured length select must not move during a run
    assert_short_held_R6: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> $stable(short_q));

    // A running conversion never jumps back toward the MSB
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (ph != PH_IDLE && $past(ph) != PH_IDLE) |-> (idx <= $past(idx)));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W = sar_seq_pkg::RES_W,
    parameter int unsigned IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  trial_cmd_t       cmd,
    input  logic [IDX_W-1:0] idx,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] trial
);

    always_ff @(posedge clk) begin
        if (rst) begin
            trial <= '0;
        end else if (cmd.clear) begin
            trial <= '0;
        end else if (cmd.set_bit) begin
            trial[idx] <= 1'b1;
        end else if (cmd.decide && cmp_hi) begin
            trial[idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int unsigned RES_W   = sar_seq_pkg::RES_W,
    parameter int unsigned SHORT_W = sar_seq_pkg::SHORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             short_sel,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             busy,
    output logic             done
);

    localparam int unsigned IDX_W = $clog2(RES_W);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    trial_cmd_t       cmd;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] trial;

    sar_ctrl #(.RES_W(RES_W), .SHORT_W(SHORT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .short_sel (short_sel),
        .busy      (busy),
        .done      (done),
        .idx       (idx),
        .cmd       (cmd)
    );

    sar_trial_reg #(.RES_W(RES_W), .IDX_W(IDX_W)) u_trial (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .idx    (idx),
        .cmp_hi (cmp_hi),
        .trial  (trial)
    );

    assign dac_code = trial;
    assign result   = busy ? '0 : trial;

    assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (dac_code == '0));

    assert_msb_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> (dac_code == MSB_ONLY));

    assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/test_sar_seq.sv
module test_sar_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        short_sel = 1'b0;
    logic        cmp_hi;
    logic [11:0] dac_code;
    logic [11:0] result;
    logic        busy;
    logic        done;
    logic [11:0] vin = 12'h000;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: high when the DAC output exceeds the input
    assign cmp_hi = (dac_code > vin);

    sar_seq i_sar_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .short_sel (short_sel),
        .cmp_hi    (cmp_hi),
        .dac_code  (dac_code),
        .result    (result),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Start a conversion, follow it to the end, check timing and result
    task automatic run_conv(input logic [11:0] v, input logic shrt, input bit poke,
                            input string tag);
        int len;
        int exp_len;
        logic [11:0] exp_res;
        exp_len = shrt ? 16 : 24;
        exp_res = shrt ? (v & 12'hFF0) : v;
        @(negedge clk);
        vin = v;
        short_sel = shrt;
        start = 1'b1;
        step();
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy"}, busy, 1);
        chk(dac_code == 12'h000, {tag, " R2 clear"}, dac_code, 0);
        len = 1;
        step();
        chk(dac_code == 12'h800, {tag, " R3 first trial"}, dac_code, 12'h800);
        chk(result == 12'h000, {tag, " R9 hidden"}, result, 0);
        len++;
        while (busy && len < 100) begin
            if (poke && len == 5) begin
                @(negedge clk);
                start = 1'b1;
                short_sel = ~shrt;
            end
            step();
            if (poke && len == 8) start = 1'b0;
            if (busy) len++;
            if (busy) chk(done == 1'b0, {tag, " R8 done early"}, done, 0);
        end
        start = 1'b0;
        chk(len == exp_len, {tag, " R5 length"}, len, exp_len);
        chk(done == 1'b1, {tag, " R8 done pulse"}, done, 1);
        chk(result == exp_res, {tag, " R4 result"}, result, exp_res);
        step();
        chk(done == 1'b0, {tag, " R8 done width"}, done, 0);
        chk(busy == 1'b0, {tag, " R7 no restart"}, busy, 0);
        chk(result == exp_res, {tag, " R9 held"}, result, exp_res);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(dac_code == 0, "R1 dac", dac_code, 0);
        chk(result == 0, "R1 result", result, 0);
        @(negedge clk);
        rst = 1'b0;
        step();
    endtask

    task automatic t_full();
        run_conv(12'h000, 1'b0, 1'b0, "full zero R4");
        run_conv(12'hFFF, 1'b0, 1'b0, "full max R4");
        run_conv(12'hA5C, 1'b0, 1'b0, "full pattern R4");
        run_conv(12'h555, 1'b0, 1'b0, "full alt R4");
        run_conv(12'h800, 1'b0, 1'b0, "full mid R3");
    endtask

    task automatic t_short();
        run_conv(12'hABC, 1'b1, 1'b0, "short R5");
        run_conv(12'h00F, 1'b1, 1'b0, "short low R5");
        run_conv(12'hFFF, 1'b1, 1'b0, "short max R5");
    endtask

    // Start pulses and a toggled select in mid-run must change nothing
    task automatic t_busy_ignore();
        run_conv(12'h5A3, 1'b0, 1'b1, "ignore full R7 R6");
        run_conv(12'h3C7, 1'b1, 1'b1, "ignore short R7 R6");
    endtask

    initial begin
        t_reset();
        t_full();
        t_short();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule